// File: doc/BRIEF.md
# Audio Sample Clock Generator

This block turns a fast master clock into the two timing signals an audio converter core needs. It produces a one-cycle internal clock enable at the master rate divided by 1, 2 or 4, and a frame (left/right) clock at the audio sample rate. Three control bytes, loaded through a simple write port, choose the prescale ratio, the divider mode and the divide coefficient. A prescale code of zero shuts everything down.

The frame divider has two variants. In preset mode, a 2-bit code picks one of three fixed ratios, each with an 8 kHz and a 16 kHz setting. One of the 16 kHz ratios is the half-integer 812.5, which the block makes by alternating frames of 812 and 813 internal clocks. In coefficient mode, a 15-bit coefficient is added to a phase accumulator on every internal enable, and the frame clock toggles each time the accumulator wraps. A preset code other than zero overrides the coefficient.

A single controller, `frame_fsm` inside the top, owns the frame clock. It has four named states: IDLE (shut down, output low), HIGH and LOW (the two phases of a preset-mode frame) and ACCUM (coefficient mode). Its transitions are: RESTART, from any state to IDLE, HIGH or ACCUM when a configuration change takes effect; HIGH_DONE, from HIGH to LOW after the high phase length; LOW_DONE, from LOW to HIGH after the low phase length, which also flips the half-integer alternation flag; and WRAP, a self-transition in ACCUM that toggles the output on an accumulator carry.

Top module: `audio_frame_clkgen`

## Requirements
- R1: Address 0x03 holds the prescale code in bits 5:4, the preset code in bits 2:1 and the rate select in bit 0. Address 0x04 bits 6:0 hold coefficient bits 14:8, and address 0x05 holds coefficient bits 7:0. Bit 7 of 0x04 and writes to any other address have no effect on either output.
- R2: Prescale code 00 keeps pclk_en and frame_clk low. Code 01 asserts pclk_en on every clock, code 10 on every second clock and code 11 on every fourth clock.
- R3: The frame period, counted in pclk_en pulses, is selected by the preset code and the rate select (0 = 8 kHz, 1 = 16 kHz). Preset 01 gives 1500 or 750, preset 10 gives 1625 or 812.5, and preset 11 gives 2400 or 1200.
- R4: Each preset-mode frame starts with frame_clk high for ceil(P/2) pulses, then goes low for floor(P/2) pulses.
- R5: Preset 10 at 16 kHz alternates periods of 812 and 813 pulses, starting with 812 after a restart, so that each pair spans 1625 pulses.
- R6: Preset code 00 selects coefficient mode. The coefficient is added to a 15-bit accumulator on each pulse, and frame_clk toggles on every carry out. This gives coef/8 toggles per 4096 pulses, within one. A coefficient of zero leaves frame_clk high.
- R7: In preset mode, writes to the coefficient registers have no effect and do not restart the divider.
- R8: In coefficient mode, changing the rate select does not affect or restart the divider.
- R9: A write that changes the prescale code, the preset code, the rate select in preset mode, or the coefficient in coefficient mode restarts the divider one clock later. The prescale phase, counters and accumulator clear, and frame_clk begins a full-length high phase.
- R10: After reset, all control fields are zero, and pclk_en and frame_clk are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| pclk_en | output | 1 | Internal clock enable, one master cycle wide |
| frame_clk | output | 1 | Frame (left/right) clock |

## Verification
The bench measures every preset ratio at both rates as exact high and low run lengths in master cycles. This catches a design that rounds the odd 1625 split the wrong way, or that divides by 812 or 813 every time instead of alternating. A design that lets ignored writes restart the divider is caught through the divide-by-4 prescaler: the bench issues the write right after an enable pulse and checks that the next pulse still arrives four cycles later rather than five. A real configuration change is used as the control case that must show five. In coefficient mode, the bench checks toggle counts against coef/8 for random coefficients and for zero. An accumulator that drops the carry, or that adds on every master cycle, gives a count that is off by a large factor.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 8;
    localparam int COEF_W  = 15;
    localparam int PSC_W   = 2;
    localparam int MODE_W  = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL    = 8'h03;
    localparam logic [ADDR_W-1:0] ADDR_COEF_HI = 8'h04;
    localparam logic [ADDR_W-1:0] ADDR_COEF_LO = 8'h05;

    typedef enum logic [PSC_W-1:0] {
        PSC_OFF  = 2'b00,
        PSC_DIV1 = 2'b01,
        PSC_DIV2 = 2'b10,
        PSC_DIV4 = 2'b11
    } psc_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HIGH  = 2'd1,
        ST_LOW   = 2'd2,
        ST_ACCUM = 2'd3
    } div_state_e;

endpackage

// File: rtl/clkgen_regs.sv
module clkgen_regs
    import clkgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output psc_e              psc_code,
    output logic [MODE_W-1:0] mode_code,
    output logic              rate_sel,
    output logic [COEF_W-1:0] coef,
    output logic              restart_q
);

    localparam int HI_W = COEF_W - DATA_W;

    logic psc_diff, mode_diff, rate_diff, hi_diff, lo_diff;
    logic ctrl_hit, hi_hit, lo_hit, changes;

    assign ctrl_hit  = wr_en && (wr_addr == ADDR_CTRL);
    assign hi_hit    = wr_en && (wr_addr == ADDR_COEF_HI);
    assign lo_hit    = wr_en && (wr_addr == ADDR_COEF_LO);

    assign psc_diff  = wr_data[5:4] != psc_code;
    assign mode_diff = wr_data[2:1] != mode_code;
    assign rate_diff = wr_data[0]   != rate_sel;
    assign hi_diff   = wr_data[HI_W-1:0] != coef[COEF_W-1:DATA_W];
    assign lo_diff   = wr_data != coef[DATA_W-1:0];

    // A write restarts the divider only if it changes what the divider uses.
    always_comb begin
        changes = 1'b0;
        if (ctrl_hit)
            changes = psc_diff || mode_diff || (rate_diff && (mode_code != '0));
        else if (hi_hit)
            changes = (mode_code == '0) && hi_diff;
        else if (lo_hit)
            changes = (mode_code == '0) && lo_diff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_code  <= PSC_OFF;
            mode_code <= '0;
            rate_sel  <= 1'b0;
            coef      <= '0;
            restart_q <= 1'b0;
        end else begin
            restart_q <= changes;
            if (ctrl_hit) begin
                psc_code  <= psc_e'(wr_data[5:4]);
                mode_code <= wr_data[2:1];
                rate_sel  <= wr_data[0];
            end
            if (hi_hit)
                coef[COEF_W-1:DATA_W] <= wr_data[HI_W-1:0];
            if (lo_hit)
                coef[DATA_W-1:0] <= wr_data;
        end
    end

endmodule

// File: rtl/clk_prescaler.sv
module clk_prescaler
    import clkgen_pkg::*;
#(
    parameter int MAX_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  psc_e psc_code,
    input  logic restart,
    output logic pclk_en
);

    localparam int CW = $clog2(MAX_DIV);

    logic [CW-1:0] phase_q;
    logic [CW-1:0] mask;

    always_comb begin
        unique case (psc_code)
            PSC_OFF:  mask = '0;
            PSC_DIV1: mask = '0;
            PSC_DIV2: mask = CW'(1);
            PSC_DIV4: mask = CW'(3);
            default:  mask = '0;
        endcase
    end

    assign pclk_en = (psc_code != PSC_OFF) && ((phase_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= '0;
        else if (restart)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

endmodule

// File: rtl/frame_ratio_sel.sv
module frame_ratio_sel
    import clkgen_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int PER_A  = 1500,
    parameter int PER_B  = 1625,
    parameter int PER_C  = 2400
) (
    input  logic [MODE_W-1:0] mode_code,
    input  logic              rate_sel,
    input  logic              alt,
    output logic [CNT_W-1:0]  hi_len,
    output logic [CNT_W-1:0]  lo_len
);

    localparam logic [CNT_W-1:0] BASE_A = CNT_W'(PER_A);
    localparam logic [CNT_W-1:0] BASE_B = CNT_W'(PER_B);
    localparam logic [CNT_W-1:0] BASE_C = CNT_W'(PER_C);

    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] per;

    always_comb begin
        unique case (mode_code)
            2'd1:    base = BASE_A;
            2'd2:    base = BASE_B;
            2'd3:    base = BASE_C;
            default: base = '0;
        endcase
    end

    // Fast rate halves the base; an odd base alternates floor and ceil.
    assign per    = rate_sel ? ((base >> 1) + CNT_W'(base[0] & alt)) : base;
    assign hi_len = (per + 1'b1) >> 1;
    assign lo_len = per >> 1;

endmodule

// File: rtl/phase_accum.sv
module phase_accum #(
    parameter int COEF_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [COEF_W-1:0] coef,
    output logic              wrap
);

    logic [COEF_W-1:0] acc_q;
    logic [COEF_W:0]   sum;

    assign sum  = {1'b0, acc_q} + {1'b0, coef};
    assign wrap = step && sum[COEF_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else if (clear)
            acc_q <= '0;
        else if (step)
            acc_q <= sum[COEF_W-1:0];
    end

endmodule

// File: rtl/audio_frame_clkgen.sv
module audio_frame_clkgen
    import clkgen_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int MAX_DIV = 4,
    parameter int PER_A   = 1500,
    parameter int PER_B   = 1625,
    parameter int PER_C   = 2400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pclk_en,
    output logic              frame_clk
);

    psc_e              psc_code;
    logic [MODE_W-1:0] mode_code;
    logic              rate_sel;
    logic [COEF_W-1:0] coef;
    logic              restart_q;
    logic [CNT_W-1:0]  hi_len, lo_len;
    logic              wrap;

    div_state_e        st_q, st_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic              alt_q, alt_n;
    logic              afr_q, afr_n;

    clkgen_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .psc_code  (psc_code),
        .mode_code (mode_code),
        .rate_sel  (rate_sel),
        .coef      (coef),
        .restart_q (restart_q)
    );

    clk_prescaler #(.MAX_DIV(MAX_DIV)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .psc_code (psc_code),
        .restart  (restart_q),
        .pclk_en  (pclk_en)
    );

    frame_ratio_sel #(
        .CNT_W (CNT_W),
        .PER_A (PER_A),
        .PER_B (PER_B),
        .PER_C (PER_C)
    ) u_ratio (
        .mode_code (mode_code),
        .rate_sel  (rate_sel),
        .alt       (alt_q),
        .hi_len    (hi_len),
        .lo_len    (lo_len)
    );

    phase_accum #(.COEF_W(COEF_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart_q),
        .step  (pclk_en && (st_q == ST_ACCUM)),
        .coef  (coef),
        .wrap  (wrap)
    );

    // frame_fsm: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            alt_q <= 1'b0;
            afr_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            alt_q <= alt_n;
            afr_q <= afr_n;
        end
    end

    // frame_fsm: transitions RESTART, HIGH_DONE, LOW_DONE, WRAP
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        alt_n = alt_q;
        afr_n = afr_q;
        if (restart_q) begin
            cnt_n = '0;
            alt_n = 1'b0;
            afr_n = 1'b1;
            if (psc_code == PSC_OFF)
                st_n = ST_IDLE;
            else if (mode_code != '0)
                st_n = ST_HIGH;
            else
                st_n = ST_ACCUM;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_n = ST_IDLE;
                end
                ST_HIGH: begin
                    if (pclk_en) begin
                        if (cnt_q == hi_len - 1'b1) begin
                            st_n  = ST_LOW;
                            cnt_n = '0;
                        end else begin
                            cnt_n = cnt_q + 1'b1;
                        end
                    end
                end
                ST_LOW: begin
                    if (pclk_en) begin
                        if (cnt_q == lo_len - 1'b1) begin
                            st_n  = ST_HIGH;
                            cnt_n = '0;
                            alt_n = ~alt_q;
                        end else begin
                            cnt_n = cnt_q + 1'b1;
                        end
                    end
                end
                ST_ACCUM: begin
                    if (wrap)
                        afr_n = ~afr_q;
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // frame_fsm: outputs
    always_comb begin
        unique case (st_q)
            ST_IDLE:  frame_clk = 1'b0;
            ST_HIGH:  frame_clk = 1'b1;
            ST_LOW:   frame_clk = 1'b0;
            ST_ACCUM: frame_clk = afr_q;
            default:  frame_clk = 1'b0;
        endcase
    end

endmodule

// File: rtl/clkgen_checker.sv
module clkgen_checker
    import clkgen_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pclk_en,
    input logic             frame_clk,
    input psc_e             psc_code,
    input logic             restart_q,
    input div_state_e       st_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] hi_len,
    input logic [CNT_W-1:0] lo_len
);

    a_r2_off_frame_low: assert property (@(posedge clk) disable iff (!rst_n)
        (psc_code == PSC_OFF && !restart_q) |-> !frame_clk);

    a_r2_div2_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (psc_code == PSC_DIV2 && pclk_en) |=> (psc_code != PSC_DIV2 || !pclk_en));

    a_r2_div4_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (psc_code == PSC_DIV4 && pclk_en) |=> (psc_code != PSC_DIV4 || !pclk_en));

    a_r4_high_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HIGH && !restart_q) |-> (cnt_q < hi_len));

    a_r4_low_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOW && !restart_q) |-> (cnt_q < lo_len));

    a_r9_restart_high: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_q && psc_code != PSC_OFF) |=> frame_clk);

    a_r4_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_clk) |-> ($past(pclk_en) || $past(restart_q)));

endmodule

bind audio_frame_clkgen clkgen_checker #(.CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pclk_en   (pclk_en),
    .frame_clk (frame_clk),
    .psc_code  (psc_code),
    .restart_q (restart_q),
    .st_q      (st_q),
    .cnt_q     (cnt_q),
    .hi_len    (hi_len),
    .lo_len    (lo_len)
);

// File: tb/test_audio_frame_clkgen.sv
module test_audio_frame_clkgen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pclk_en;
    logic       frame_clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    audio_frame_clkgen i_audio_frame_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pclk_en   (pclk_en),
        .frame_clk (frame_clk)
    );

    function automatic int div_of(int psc);
        return (psc == 1) ? 1 : (psc == 2) ? 2 : 4;
    endfunction

    function automatic int period_of(int mode, int rate, int alt);
        case (mode)
            1: return rate ? 750  : 1500;
            2: return rate ? (alt ? 813 : 812) : 1625;
            default: return rate ? 1200 : 2400;
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cfg(int psc, int mode, int rate);
        wr(8'h03, 8'((psc << 4) | (mode << 1) | rate));
    endtask

    task automatic sync_rise();
        do @(negedge clk); while (frame_clk);
        do @(negedge clk); while (!frame_clk);
    endtask

    // Called at the first high sample; returns at the next first high sample.
    task automatic measure(output int hi, output int lo);
        hi = 0; lo = 0;
        while (frame_clk)  begin hi++; @(negedge clk); end
        while (!frame_clk) begin lo++; @(negedge clk); end
    endtask

    task automatic pulse_gap(output int n);
        do @(negedge clk); while (!pclk_en);
        n = 0;
        do begin @(negedge clk); n++; end while (!pclk_en);
    endtask

    // Write right after an enable pulse (divide by 4); 4 = no restart, 5 = restart.
    task automatic gap_after_write(logic [7:0] a, logic [7:0] d, output int n);
        do @(negedge clk); while (!pclk_en);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        n = 1;
        while (!pclk_en) begin @(negedge clk); n++; end
    endtask

    task automatic count_toggles(int win, output int tg);
        logic prev;
        prev = frame_clk;
        tg = 0;
        repeat (win) begin
            @(negedge clk);
            if (frame_clk != prev) tg++;
            prev = frame_clk;
        end
    endtask

    task automatic check_preset(int psc, int mode, int rate, string req);
        int hi, lo, p, d;
        cfg(psc, mode, rate);
        d = div_of(psc);
        p = period_of(mode, rate, 0);
        sync_rise();
        measure(hi, lo);
        check(hi == ((p + 1) / 2) * d, req, "high run", hi, ((p + 1) / 2) * d);
        check(lo == (p / 2) * d, req, "low run", lo, (p / 2) * d);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int n, hi, lo, hi2, lo2, tg, coef, psc, mode, rate;
        void'($urandom(32'd7340));

        repeat (3) @(negedge clk);
        // R10: outputs low while held in reset and after release
        check(!pclk_en && !frame_clk, "R10", "outputs in reset", {pclk_en, frame_clk}, 0);
        rst_n = 1'b1;
        tg = 0;
        repeat (20) begin @(negedge clk); if (pclk_en || frame_clk) tg++; end
        check(tg == 0, "R10", "outputs idle after reset", tg, 0);

        // R2: prescaler spacing
        cfg(1, 1, 0); pulse_gap(n); check(n == 1, "R2", "div1 gap", n, 1);
        cfg(2, 1, 0); pulse_gap(n); check(n == 2, "R2", "div2 gap", n, 2);
        cfg(3, 1, 0); pulse_gap(n); check(n == 4, "R2", "div4 gap", n, 4);

        // R3 / R4: directed preset ratios
        check_preset(1, 1, 0, "R3");
        check_preset(1, 1, 1, "R3");
        check_preset(1, 2, 0, "R4");
        check_preset(2, 3, 1, "R3");
        check_preset(1, 3, 0, "R4");

        // R5: half-integer alternation and first frame after restart
        cfg(1, 2, 1);
        @(negedge clk);
        measure(hi, lo);
        measure(hi2, lo2);
        check(hi == 406 && lo == 406, "R5", "first frame 812", hi + lo, 812);
        check(hi2 == 407 && lo2 == 406, "R5", "second frame 813", hi2 + lo2, 813);
        check(hi + lo + hi2 + lo2 == 1625, "R5", "pair span", hi + lo + hi2 + lo2, 1625);

        // R9: a real change restarts into a full high phase
        cfg(2, 1, 0);
        @(negedge clk);
        check(frame_clk == 1'b1, "R9", "high after restart", frame_clk, 1);
        measure(hi, lo);
        check(hi == 750 * 2, "R9", "full first high", hi, 1500);

        // R3: random preset settings
        for (int i = 0; i < 5; i++) begin
            psc  = $urandom_range(1, 2);
            mode = $urandom_range(1, 3);
            rate = $urandom_range(0, 1);
            if (mode == 2 && rate == 1) rate = 0;
            check_preset(psc, mode, rate, "R3");
        end

        // R7: coefficient writes in preset mode are ignored; R9 control case
        cfg(3, 1, 0);
        gap_after_write(8'h04, 8'h55, n); check(n == 4, "R7", "coef hi write no restart", n, 4);
        gap_after_write(8'h05, 8'hA3, n); check(n == 4, "R7", "coef lo write no restart", n, 4);
        gap_after_write(8'h03, 8'h33, n); check(n == 5, "R9", "rate change restarts", n, 5);
        // R1: unmapped address ignored
        gap_after_write(8'h07, 8'hFF, n); check(n == 4, "R1", "unmapped write ignored", n, 4);

        // R8: rate bit ignored in coefficient mode; R1: bit 7 of 0x04 ignored
        cfg(3, 0, 0);
        wr(8'h04, 8'h12); wr(8'h05, 8'h34);
        gap_after_write(8'h03, 8'h31, n); check(n == 4, "R8", "rate bit no restart", n, 4);
        gap_after_write(8'h04, 8'h92, n); check(n == 4, "R1", "bit7 of coef hi ignored", n, 4);
        gap_after_write(8'h05, 8'h35, n); check(n == 5, "R9", "coef change restarts", n, 5);

        // R6: accumulator toggle counts
        cfg(1, 0, 0);
        for (int i = 0; i < 5; i++) begin
            coef = (i == 0) ? 32767 : $urandom_range(512, 32767);
            wr(8'h04, 8'(coef >> 8));
            wr(8'h05, 8'(coef & 255));
            repeat (16) @(negedge clk);
            count_toggles(4096, tg);
            check(tg >= coef / 8 - 1 && tg <= coef / 8 + 1, "R6", "toggles per 4096", tg, coef / 8);
        end
        wr(8'h04, 8'h00); wr(8'h05, 8'h00);
        repeat (4) @(negedge clk);
        count_toggles(512, tg);
        check(tg == 0 && frame_clk, "R6", "zero coef holds high", tg, 0);

        // R2: shutdown code silences both outputs
        cfg(1, 1, 0);
        repeat (100) @(negedge clk);
        cfg(0, 1, 0);
        @(negedge clk);
        tg = 0;
        repeat (200) begin @(negedge clk); if (pclk_en || frame_clk) tg++; end
        check(tg == 0, "R2", "shutdown quiet", tg, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule